// File: doc/BRIEF.md
# Interrupt Acceptance and Priority Arbiter

This block picks which pending interrupt source the processor takes at an instruction boundary. Each source has a sticky request flag, which a one-cycle hardware pulse sets, and an enable bit. A single global mask bit blocks all acceptance while it is 1. Software changes the enables, the flags and the mask through a small write port. The arbiter decides only on the cycle where the instruction-end strobe is high. On that cycle it accepts the enabled, flagged source with the lowest index, as long as the mask is 0.

Register writes do not act at once. Each write is held in shadow state and is committed on the next instruction-end strobe, after that boundary's decision has been made. As a result, an instruction that disables a source or clears its flag does not stop that source from being accepted at the end of the same instruction. The one exception is a higher-priority source that wins at that boundary. In that case the disabled source is dropped and is not kept for later. Accepting a source also sets the mask, so a second source cannot be taken until software clears the mask.

The write port decodes `wr_sel` as follows:
- 2'b00 loads the enable register.
- 2'b01 writes the flag register. A 0 bit requests a clear and a 1 bit does nothing.
- 2'b10 loads the mask from `wr_data[0]`.
- 2'b11 is ignored.

Top module: `irq_arbiter`

## Requirements
- R1: After reset all flags and enables are 0, the mask is 1 and `accept` is 0.
- R2: A one-cycle `set_req[i]` pulse sets flag i. The flag stays set until a software clear commits, and acceptance does not clear it.
- R3: When `instr_end` is high, the mask is 0 and some source has both flag and enable set, `accept` is high for exactly the next cycle. In that cycle `accept_vec` equals VEC_BASE plus the winner's index.
- R4: When several sources are eligible at the same boundary, the lowest index wins.
- R5: An enable write (`wr_sel`=00) takes effect only on the next `instr_end`. The decision on that strobe still uses the old enables, so a source disabled by the ending instruction can still be accepted.
- R6: A flag clear (`wr_sel`=01, 0 bits) takes effect only on the next `instr_end`. The decision on that strobe still sees the old flag.
- R7: If a higher-priority source wins at the boundary where a lower source's disable commits, the lower source is never accepted afterwards while it stays disabled, even once the mask is cleared.
- R8: Acceptance forces the mask to 1 on the same strobe, overriding any pending mask write. No further acceptance happens until a mask write of 0 (`wr_sel`=10) commits.
- R9: While the mask is 1 at a boundary, nothing is accepted, whatever enable or flag clears are pending.
- R10: A `set_req` pulse for a flag wins over a pending or simultaneous software clear of the same flag.
- R11: Writing 1 bits to the flag register never sets a flag, and writes with `wr_sel`=11 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_req | input | NSRC | Per-source request pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 enable, 01 flag, 10 mask, 11 none |
| wr_data | input | NSRC | Write data (mask uses bit 0) |
| instr_end | input | 1 | Instruction-boundary strobe |
| accept | output | 1 | One-cycle acceptance pulse |
| accept_vec | output | VEC_W | Vector number of the accepted source |
| flag_q | output | NSRC | Live request flags |
| en_q | output | NSRC | Live enable bits |
| mask_q | output | 1 | Live global mask |

## Verification
The assertions assume two things about the inputs. First, `instr_end` marks a real boundary. Second, `VEC_BASE + NSRC` fits in `VEC_W` bits, so that the winner's index can be recovered by subtracting the base from `accept_vec`. Between two strobes, the properties also rely on the live enables, flags and mask changing only through the set pulses. The stimulus drives every write and every strobe on the falling edge and holds each strobe for a single cycle. The races are staged by putting writes and set pulses inside the same instruction window that the strobe then closes.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC     = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  set_req,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [NSRC-1:0]  wr_data,
  input  logic             instr_end,
  output logic             accept,
  output logic [VEC_W-1:0] accept_vec,
  output logic [NSRC-1:0]  flag_q,
  output logic [NSRC-1:0]  en_q,
  output logic             mask_q
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [1:0] SEL_EN = 2'b00, SEL_FLG = 2'b01, SEL_MSK = 2'b10;

  logic [NSRC-1:0] en_sh, clr_pend;
  logic            en_pend, mask_sh, mask_pend;

  wire wr_en_reg  = wr_en && (wr_sel == SEL_EN);
  wire wr_flg_reg = wr_en && (wr_sel == SEL_FLG);
  wire wr_msk_reg = wr_en && (wr_sel == SEL_MSK);

  wire [NSRC-1:0] clr_now = wr_flg_reg ? ~wr_data : '0;
  wire [NSRC-1:0] clr_acc = (clr_pend | clr_now) & ~set_req;

  wire [NSRC-1:0] en_next   = wr_en_reg ? wr_data : (en_pend ? en_sh : en_q);
  wire            mask_next = wr_msk_reg ? wr_data[0] : (mask_pend ? mask_sh : mask_q);

  wire [NSRC-1:0] elig = mask_q ? '0 : (flag_q & en_q);
  wire            any_elig = |elig;

  logic [IW-1:0] win;
  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= '0;
      en_q       <= '0;
      mask_q     <= 1'b1;
      en_sh      <= '0;
      en_pend    <= 1'b0;
      mask_sh    <= 1'b1;
      mask_pend  <= 1'b0;
      clr_pend   <= '0;
      accept     <= 1'b0;
      accept_vec <= '0;
    end else if (instr_end) begin
      accept    <= any_elig;
      if (any_elig) accept_vec <= VEC_W'(VEC_BASE) + VEC_W'(win);
      flag_q    <= (flag_q & ~clr_acc) | set_req;
      en_q      <= en_next;
      mask_q    <= any_elig ? 1'b1 : mask_next;
      en_pend   <= 1'b0;
      mask_pend <= 1'b0;
      clr_pend  <= '0;
    end else begin
      accept   <= 1'b0;
      flag_q   <= flag_q | set_req;
      clr_pend <= clr_acc;
      if (wr_en_reg) begin
        en_sh   <= wr_data;
        en_pend <= 1'b1;
      end
      if (wr_msk_reg) begin
        mask_sh   <= wr_data[0];
        mask_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NSRC     = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_end,
  input logic             accept,
  input logic [VEC_W-1:0] accept_vec,
  input logic [NSRC-1:0]  flag_q,
  input logic [NSRC-1:0]  en_q,
  input logic             mask_q
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] elig_d, low_mask;
  logic            mask_d;
  logic [VEC_W-1:0] off;
  logic [IW-1:0]    idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      elig_d <= '0;
      mask_d <= 1'b1;
    end else begin
      elig_d <= flag_q & en_q;
      mask_d <= mask_q;
    end

  assign off = accept_vec - VEC_W'(VEC_BASE);
  assign idx = off[IW-1:0];
  always_comb
    for (int i = 0; i < NSRC; i++) low_mask[i] = (i < int'(idx));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
  a_r3_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(instr_end));
  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> elig_d[idx]);
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((elig_d & low_mask) == '0));
  a_r8_mask_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> mask_q);
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !mask_d);
  a_r5_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_end |=> $stable(en_q));
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_end |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_end |=> $stable(mask_q));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_end(instr_end), .accept(accept),
  .accept_vec(accept_vec), .flag_q(flag_q), .en_q(en_q), .mask_q(mask_q)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  localparam int NSRC = 8, VEC_W = 8, VEC_BASE = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] set_req = '0, wr_data = '0;
  logic wr_en = 1'b0, instr_end = 1'b0;
  logic [1:0] wr_sel = 2'b00;
  logic accept, mask_q;
  logic [VEC_W-1:0] accept_vec;
  logic [NSRC-1:0] flag_q, en_q;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .instr_end(instr_end), .accept(accept),
    .accept_vec(accept_vec), .flag_q(flag_q), .en_q(en_q), .mask_q(mask_q));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [NSRC-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int i);
    set_req[i] = 1'b1;
    @(negedge clk);
    set_req = '0;
  endtask

  task automatic boundary(output logic acc, output logic [VEC_W-1:0] v);
    instr_end = 1'b1;
    @(negedge clk);
    instr_end = 1'b0;
    acc = accept; v = accept_vec;
  endtask

  task automatic expect_accept(input string req, input int src);
    logic a; logic [VEC_W-1:0] v;
    boundary(a, v);
    chk(req, a, 1);
    chk(req, v, VEC_BASE + src);
    @(negedge clk);
    chk(req, accept, 0);
  endtask

  task automatic expect_none(input string req);
    logic a; logic [VEC_W-1:0] v;
    boundary(a, v);
    chk(req, a, 0);
  endtask

  task automatic set_mask(input logic m);
    wr(2'b10, {{(NSRC-1){1'b0}}, m});
    expect_none("R9 mask commit");
    chk("R8", mask_q, m);
  endtask

  task automatic t_reset;
    chk("R1 flags", flag_q, 0);
    chk("R1 enables", en_q, 0);
    chk("R1 mask", mask_q, 1);
    chk("R1 accept", accept, 0);
  endtask

  task automatic t_basic;
    wr(2'b00, 8'hFF);
    chk("R5 enable deferred", en_q, 0);
    set_mask(1'b0);
    chk("R5 enable committed", en_q, 8'hFF);
    pulse(3);
    chk("R2 flag set", flag_q, 8'h08);
    expect_accept("R3", 3);
    chk("R8 mask set on accept", mask_q, 1);
    chk("R2 flag not self-cleared", flag_q, 8'h08);
    expect_none("R8 no second accept");
    wr(2'b01, ~8'h08);
    expect_none("R9");
    chk("R6 flag clear committed", flag_q, 0);
  endtask

  task automatic t_priority;
    pulse(5); pulse(2);
    set_mask(1'b0);
    expect_accept("R4", 2);
    wr(2'b01, 8'h00);
    expect_none("R9");
    chk("R4 cleanup", flag_q, 0);
  endtask

  task automatic t_enable_race;
    set_mask(1'b0);
    wr(2'b00, ~8'h10);
    pulse(4);
    chk("R5 enable still live", en_q[4], 1);
    expect_accept("R5 race", 4);
    chk("R5 disable committed", en_q, 8'hEF);
    wr(2'b01, 8'h00);
    expect_none("R9");
    wr(2'b00, 8'hFF);
    expect_none("R9");
  endtask

  task automatic t_flag_race;
    pulse(6);
    set_mask(1'b0);
    wr(2'b01, ~8'h40);
    chk("R6 flag still live", flag_q[6], 1);
    expect_accept("R6 race", 6);
    chk("R6 flag cleared after", flag_q, 0);
  endtask

  task automatic t_higher_wins;
    pulse(1);
    set_mask(1'b0);
    wr(2'b00, ~8'h20);
    pulse(5);
    expect_accept("R7 higher wins", 1);
    chk("R7 disable committed", en_q[5], 0);
    wr(2'b01, ~8'h02);
    expect_none("R9");
    set_mask(1'b0);
    expect_none("R7 dropped source");
    chk("R7 flag kept", flag_q, 8'h20);
    wr(2'b01, 8'h00);
    expect_none("R7");
    wr(2'b00, 8'hFF);
    set_mask(1'b1);
  endtask

  task automatic t_masked;
    pulse(0);
    wr(2'b00, 8'hFE);
    expect_none("R9 masked race");
    pulse(7);
    expect_none("R9 masked enabled");
    chk("R9 flags", flag_q, 8'h81);
    wr(2'b01, 8'h00);
    expect_none("R9");
    wr(2'b00, 8'hFF);
    expect_none("R9");
  endtask

  task automatic t_set_wins;
    set_req[2] = 1'b1; wr_en = 1'b1; wr_sel = 2'b01; wr_data = 8'h00;
    @(negedge clk);
    set_req = '0; wr_en = 1'b0;
    expect_none("R10");
    chk("R10 same-cycle set wins", flag_q, 8'h04);
    wr(2'b01, 8'h00);
    pulse(3);
    expect_none("R10");
    chk("R10 set beats pending clear", flag_q, 8'h08);
    wr(2'b01, 8'h00);
    expect_none("R10");
  endtask

  task automatic t_write_one;
    wr(2'b01, 8'hFF);
    expect_none("R11");
    chk("R11 flag write of ones", flag_q, 0);
    wr(2'b11, 8'h00);
    expect_none("R11");
    chk("R11 sel 11 enables", en_q, 8'hFF);
    chk("R11 sel 11 mask", mask_q, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_basic;
    t_priority;
    t_enable_race;
    t_flag_race;
    t_higher_wins;
    t_masked;
    t_set_wins;
    t_write_one;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule